// File: doc/BRIEF.md
# Slow Oscillator Startup and Ready Controller

This block manages a low-power slow oscillator. Software writes a control word that holds an enable bit, a mode bit and a startup-time code. The mode bit selects a crystal or an external clock. Once the oscillator runs, the block counts slow-clock ticks. When the programmed number of ticks has passed, it raises a ready flag. A rising ready flag latches an interrupt flag. That flag is qualified by an interrupt-enable bit and stays set until software clears it.

The analog oscillator is not part of this block. Each slow-clock cycle reaches the controller as a one-cycle tick on the system clock. A static-sleep input shuts the oscillator down, and every other sleep state leaves it running. The two oscillator pins are handed back to general-purpose I/O whenever the oscillator does not need them.

The asynchronous power-on reset clears everything. The synchronous system reset clears only the interrupt state. The control word and the ready state survive it, because a crystal start can take a long time.

Top module: `osc32_ctl`

## Requirements
- R1: After power-on reset, the enable, mode and code fields are 0. `osc_run_o`, `ready_o` and `irq_o` are 0, and `xin_gpio_o` and `xout_gpio_o` are both 1.
- R2: A write to address 0 loads the control word: bit 0 is enable, bit 1 is mode (1 = external clock) and bits 4:2 are the startup code. `osc_run_o` equals enable AND NOT `static_mode_i`.
- R3: The startup target N is 0 for code 0 and 2^(2*code+2) ticks for codes 1 to 7, which gives 16 up to 65536. With `osc_tick_i` held at 1, `ready_o` rises at the N-th clock edge after the write edge that starts the run, and at the first edge when the code is 0.
- R4: Clearing enable drops `ready_o` in the same cycle that the enable bit falls. A later enable counts the full target again.
- R5: While `static_mode_i` is 1, `osc_run_o` and `ready_o` are 0 at once. After `static_mode_i` falls, the full startup count runs again before `ready_o` returns.
- R6: A 0-to-1 transition of `ready_o` sets the interrupt flag one cycle later. `irq_o` equals the flag AND the interrupt-enable bit, which is bit 0 at address 1. Writing 1 to bit 0 at address 2 clears the flag.
- R7: When a flag set and a flag clear land in the same cycle, the set wins.
- R8: `sys_rst_i` clears the interrupt-enable bit and the interrupt flag. The control word and the ready state keep their values.
- R9: With enable at 0, both pin-release outputs are 1. With enable at 1 in crystal mode, both are 0. With enable at 1 in external mode, only `xout_gpio_o` is 1.
- R10: A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | Non-power-on system reset, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| osc_tick_i | input | 1 | One pulse per slow-oscillator cycle |
| static_mode_i | input | 1 | Static sleep mode active |
| osc_run_o | output | 1 | Oscillator enable to the analog cell |
| ready_o | output | 1 | Startup complete |
| irq_o | output | 1 | Interrupt request |
| xin_gpio_o | output | 1 | Input pin released to GPIO |
| xout_gpio_o | output | 1 | Output pin released to GPIO |

## Verification
The interrupt flag can receive a set and a clear in the same cycle. This happens when a software clear write lands on the edge where the delayed rise of ready is detected. The bench enables a 16-tick startup, then times the clear write so that its edge is the 17th after the enable. It expects `irq_o` to stay high, and a second, isolated clear is then expected to drop it. Static-mode entry and the ready count restart are also exercised together, and the bench checks that the full count is paid again after the sleep ends.

// File: rtl/osc32_pkg.sv
package osc32_pkg;
  parameter int CODE_W = 3;
  parameter int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_IRQEN  = 2'd1,
    REG_IRQCLR = 2'd2,
    REG_RSVD   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              ext_mode;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/osc32_regs.sv
module osc32_regs
  import osc32_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              irq_en_o,
  output logic              irq_clr_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  irq_en_q;
  reg_addr_e addr;

  assign addr = reg_addr_e'(wr_addr_i);

  // control word survives system reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && addr == REG_CTRL) begin
      ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
    end else if (sys_rst_i) begin
      irq_en_q <= 1'b0;
    end else if (wr_en_i && addr == REG_IRQEN) begin
      irq_en_q <= wr_data_i[0];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign irq_en_o  = irq_en_q;
  assign irq_clr_o = wr_en_i && (addr == REG_IRQCLR) && wr_data_i[0];
endmodule

// File: rtl/osc32_startup.sv
module osc32_startup #(
  parameter int CODE_W = 3,
  parameter int BASE   = 2,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ready_o
);
  localparam int MAX_SH = BASE + STEP * ((1 << CODE_W) - 1);
  localparam int CNT_W  = MAX_SH + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_inc;
  logic             rdy_q;

  always_comb begin
    if (code_i == '0) target = '0;
    else              target = CNT_W'(1) << (BASE + STEP * int'(code_i));
  end

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (target == '0) begin
        rdy_q <= 1'b1;
      end else if (tick_i) begin
        // >= keeps a shrunk code from stalling the count
        if (cnt_inc >= target) begin
          rdy_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  // drops in the cycle the run request falls
  assign ready_o = rdy_q & run_i;
endmodule

// File: rtl/osc32_irq.sv
module osc32_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic ready_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic rdy_d_q;
  logic flag_q;
  logic rise;

  assign rise = ready_i & ~rdy_d_q;

  // edge history kept across system reset: no spurious edge afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_d_q <= 1'b0;
    else         rdy_d_q <= ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (sys_rst_i) begin
      flag_q <= 1'b0;
    end else if (rise) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/osc32_ctl.sv
module osc32_ctl
  import osc32_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              osc_tick_i,
  input  logic              static_mode_i,
  output logic              osc_run_o,
  output logic              ready_o,
  output logic              irq_o,
  output logic              xin_gpio_o,
  output logic              xout_gpio_o
);
  ctrl_t ctrl;
  logic  irq_en;
  logic  irq_clr;
  logic  run;
  logic  ready;
  logic  irq_flag;
  logic  osc_en;

  osc32_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .irq_en_o  (irq_en),
    .irq_clr_o (irq_clr)
  );

  assign osc_en = ctrl.en;
  assign run    = osc_en & ~static_mode_i;

  osc32_startup #(.CODE_W(CODE_W)) u_startup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (osc_tick_i),
    .code_i  (ctrl.code),
    .ready_o (ready)
  );

  osc32_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .ready_i   (ready),
    .irq_en_i  (irq_en),
    .clr_i     (irq_clr),
    .flag_o    (irq_flag),
    .irq_o     (irq_o)
  );

  assign osc_run_o   = run;
  assign ready_o     = ready;
  assign xin_gpio_o  = ~osc_en;
  assign xout_gpio_o = ~osc_en | ctrl.ext_mode;
endmodule

// File: rtl/osc32_ctl_chk.sv
module osc32_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_rst_i,
  input logic osc_en,
  input logic irq_flag,
  input logic osc_run_o,
  input logic ready_o,
  input logic irq_o,
  input logic xin_gpio_o,
  input logic xout_gpio_o
);
  AST_READY_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(osc_run_o)); // R3

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_run_o) |-> !ready_o); // R4

  AST_STATIC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_run_o |-> !ready_o); // R5

  AST_FLAG_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !sys_rst_i) |=> irq_flag); // R6

  AST_SYSRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> !irq_o); // R8

  AST_PINS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en |-> (xin_gpio_o && xout_gpio_o)); // R9

  AST_PIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_run_o |-> !xin_gpio_o); // R9
endmodule

bind osc32_ctl osc32_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_rst_i   (sys_rst_i),
  .osc_en      (osc_en),
  .irq_flag    (irq_flag),
  .osc_run_o   (osc_run_o),
  .ready_o     (ready_o),
  .irq_o       (irq_o),
  .xin_gpio_o  (xin_gpio_o),
  .xout_gpio_o (xout_gpio_o)
);

// File: tb/osc32_ctl_tb.sv
module osc32_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b1;
  logic       stat = 1'b0;
  logic       run, ready, irq, xin_g, xout_g;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc32_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .osc_tick_i(tick), .static_mode_i(stat),
    .osc_run_o(run), .ready_o(ready), .irq_o(irq),
    .xin_gpio_o(xin_g), .xout_gpio_o(xout_g)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        xin;
    logic        xout;
    logic [31:0] lat; // 0: never ready
  } vec_t;

  localparam int NV = 6;
  localparam int CAP = 70000;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 1'b0, 1'b0, 32'd1},
    '{8'h09, 1'b0, 1'b0, 32'd64},
    '{8'h0F, 1'b0, 1'b1, 32'd256},
    '{8'h1D, 1'b0, 1'b0, 32'd65536},
    '{8'h06, 1'b1, 1'b1, 32'd0},
    '{8'h07, 1'b0, 1'b1, 32'd16}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called and returns at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic latency(output int k);
    k = 0;
    while (!ready && k < CAP) begin
      @(negedge clk);
      k++;
    end
    if (!ready) k = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int k;
    #1;
    chk("R1 run", run, 0);
    chk("R1 ready", ready, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pins", {xin_g, xout_g}, 2'b11);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset pins", {xin_g, xout_g}, 2'b11);

    for (int v = 0; v < NV; v++) begin
      wr(2'd0, 8'h00);
      chk("R4 ready off", ready, 0);
      wr(2'd0, VECS[v].ctrl);
      chk("R2 run", run, VECS[v].ctrl[0]);
      chk("R9 xin", xin_g, VECS[v].xin);
      chk("R9 xout", xout_g, VECS[v].xout);
      latency(k);
      chk("R3 latency", k, VECS[v].lat);
    end

    // R6: flag pending from earlier rises, qualified by enable
    chk("R6 masked", irq, 0);
    wr(2'd1, 8'h01);
    chk("R6 enabled", irq, 1);
    wr(2'd2, 8'h01);
    chk("R6 cleared", irq, 0);

    // R4 disable drops ready at once
    wr(2'd0, 8'h06);
    chk("R4 ready drop", ready, 0);

    // R7: clear lands on the edge the flag sets
    wr(2'd0, 8'h07);
    idle(16);
    chk("R3 ready at 16", ready, 1);
    chk("R7 pre", irq, 0);
    wr(2'd2, 8'h01);
    chk("R7 set wins", irq, 1);
    wr(2'd2, 8'h01);
    chk("R6 clear after", irq, 0);

    // R5 static mode
    stat = 1'b1;
    #1;
    chk("R5 run off", run, 0);
    chk("R5 ready off", ready, 0);
    idle(3);
    stat = 1'b0;
    latency(k);
    chk("R5 recount", k, 16);
    @(negedge clk);
    chk("R6 irq after wake", irq, 1);

    // R8 system reset
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    chk("R8 irq", irq, 0);
    chk("R8 ready kept", ready, 1);
    chk("R8 run kept", run, 1);
    chk("R8 mode kept", xout_g, 1);
    wr(2'd1, 8'h01);
    chk("R8 flag cleared", irq, 0);

    // R10 reserved address
    wr(2'd3, 8'hFF);
    idle(2);
    chk("R10 run", run, 1);
    chk("R10 pins", {xin_g, xout_g}, 2'b01);
    chk("R10 ready", ready, 1);
    chk("R10 irq", irq, 0);

    wr(2'd0, 8'h1C);
    chk("R9 off pins", {xin_g, xout_g}, 2'b11);
    chk("R2 off run", run, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule